// File: doc/BRIEF.md
# Tagged Fan-In / Fan-Out Pipeline

This block lets four independent requesters share one three-stage arithmetic pipeline. Each requester drives its own input port with a valid/ready handshake and two operands. A round-robin arbiter admits at most one item per cycle. It stamps the item with the number of the port that sent it. That stamp rides unchanged through every stage. At the far end it selects the single output port that may present the result.

The operation is a placeholder: the result is the sum of the two operands, wrapped to the data width. Because every item follows the same path through a single in-order pipeline, each requester receives its own results in the order in which they were accepted. When the output port named by the last stage is not ready, the whole pipeline holds, and no new item is admitted.

Top module: `tagfan_pipe`

## Requirements
- R1: While reset is held, and afterwards until an item has been accepted, every out_valid bit is low.
- R2: At most one in_ready bit is high in any cycle, and in_ready is high only for a port whose in_valid is high; a transfer happens only where both are high.
- R3: When all four ports hold in_valid high and no output stalls, successive grants rotate through the ports in increasing index order, wrapping from 3 to 0.
- R4: The result out_z equals (a + b) mod 2^W, where a is the port's slice in_a[p*W +: W] and b is in_b[p*W +: W]; carries out of the top bit are dropped.
- R5: A result from input port p appears only on out_valid[p], with out_id equal to p; at most one out_valid bit is high at a time.
- R6: For each port, results are delivered in the order in which that port's inputs were accepted.
- R7: With all stages empty and outputs ready, an item accepted in cycle c is presented on its output in cycle c+3 and not earlier.
- R8: While the presented result's out_ready is low, out_valid, out_z and out_id keep their values and every in_ready bit is low.
- R9: With idle gaps of 0 to 3 cycles between items on every port and randomly withheld out_ready, every accepted item is eventually delivered to its own port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N | Per-port item valid |
| in_ready | output | N | Per-port grant; transfer when valid and ready are both high |
| in_a | input | N*W | First operand, port p at bits [p*W +: W] |
| in_b | input | N*W | Second operand, port p at bits [p*W +: W] |
| out_valid | output | N | Result valid, at most one bit set, index equals source port |
| out_ready | input | N | Per-port result acceptance |
| out_z | output | W | Result, shared by all output ports, meaningful with out_valid |
| out_id | output | log2(N) | Source port of the presented result |

## Verification
A single item on one port into an empty pipeline shows the exact latency and checks that nothing appears early. Holding all four ports valid at once shows the grant order and would expose a fixed-priority arbiter. Random gaps on every port with random output stalls, using operands that include all-ones values, exercise wrap-around addition. They show whether a stall corrupts or loses an item. They also show whether a result can escape to the wrong port or overtake an earlier one from the same port. A behavioural model with one queue per port checks every delivered result against the order in which that port's items were accepted.

// File: rtl/tagfan_pipe.sv
module tagfan_pipe #(
  parameter int W = 32,
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]   in_valid,
  output logic [N-1:0]   in_ready,
  input  logic [N*W-1:0] in_a,
  input  logic [N*W-1:0] in_b,
  output logic [N-1:0]   out_valid,
  input  logic [N-1:0]   out_ready,
  output logic [W-1:0]   out_z,
  output logic [IW-1:0]  out_id
);

  logic [IW-1:0] rr, win;
  logic          found, advance, take;
  logic          v0, v1, v2;
  logic [W-1:0]  a0, b0, z1, z2;
  logic [IW-1:0] id0, id1, id2;

  always_comb begin
    win   = rr;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (int'(rr) + k) % N;
      if (!found && in_valid[j]) begin
        win   = IW'(j);
        found = 1'b1;
      end
    end
  end

  assign advance   = !v2 || out_ready[id2];
  assign take      = advance && found;
  assign in_ready  = take ? (N'(1) << win) : '0;
  assign out_valid = v2 ? (N'(1) << id2) : '0;
  assign out_z     = z2;
  assign out_id    = id2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v0 <= 1'b0;
      v1 <= 1'b0;
      v2 <= 1'b0;
      rr <= '0;
    end else if (advance) begin
      v0 <= take;
      v1 <= v0;
      v2 <= v1;
      if (take) rr <= (win == IW'(N - 1)) ? '0 : win + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (advance) begin
      if (take) begin
        a0  <= in_a[win*W +: W];
        b0  <= in_b[win*W +: W];
        id0 <= win;
      end
      z1  <= a0 + b0;
      id1 <= id0;
      z2  <= z1;
      id2 <= id1;
    end
  end

  p_ready_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready));
  p_ready_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready & ~in_valid) == '0);
  p_out_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_valid));
  p_out_id_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_valid) |-> out_valid[out_id]);
  p_stall_noaccept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(out_valid & ~out_ready)) |-> (in_ready == '0));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(out_valid & ~out_ready)) |=> ($stable(out_valid) && $stable(out_z) && $stable(out_id)));

endmodule

// File: tb/sim_tagfan_pipe.sv
module sim_tagfan_pipe;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int N = 4;
  localparam int NITEM = 25;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   in_valid = '0;
  logic [N-1:0]   in_ready;
  logic [N*W-1:0] in_a = '0;
  logic [N*W-1:0] in_b = '0;
  logic [N-1:0]   out_valid;
  logic [N-1:0]   out_ready = '1;
  logic [W-1:0]   out_z;
  logic [1:0]     out_id;

  tagfan_pipe #(.W(W), .N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_z(out_z), .out_id(out_id));

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  logic [W-1:0] expq [N][$];
  bit           pend [N];
  logic [W-1:0] pa [N], pb [N];
  int           gap [N], left [N], got [N];
  int           gap_max = 0, last_grant = -1, seqn = 0;
  bit           rand_rdy = 0, rr_on = 0;
  bit           prev_stall = 0;
  logic [N-1:0] prev_ov;
  logic [W-1:0] prev_z;
  logic [1:0]   prev_id;

  task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic new_item(int p);
    seqn++;
    pa[p] = (seqn % 5 == 0) ? '1 : $urandom;
    pb[p] = (seqn % 7 == 0) ? '1 : $urandom;
    pend[p] = 1;
  endtask

  task automatic step();
    @(negedge clk);
    for (int p = 0; p < N; p++) begin
      in_valid[p] = pend[p];
      in_a[p*W +: W] = pa[p];
      in_b[p*W +: W] = pb[p];
    end
    out_ready = rand_rdy ? 4'($urandom_range(0, 15)) : 4'hF;
    #1;
    cyc++;
    chk(((in_ready & ~in_valid) == 0) && ($countones(in_ready) <= 1), "R2 grant", W'(in_ready), W'(in_valid));
    chk($countones(out_valid) <= 1, "R5 single output", W'(out_valid), 0);
    if (prev_stall)
      chk(out_valid == prev_ov && out_z == prev_z && out_id == prev_id, "R8 hold", out_z, prev_z);
    prev_stall = |(out_valid & ~out_ready);
    if (prev_stall) chk(in_ready == 0, "R8 no accept in stall", W'(in_ready), 0);
    prev_ov = out_valid; prev_z = out_z; prev_id = out_id;
    for (int p = 0; p < N; p++) begin
      if (in_valid[p] && in_ready[p]) begin
        expq[p].push_back(pa[p] + pb[p]);
        pend[p] = 0;
        left[p]--;
        gap[p] = $urandom_range(0, gap_max);
        if (rr_on) begin
          if (last_grant >= 0) chk(p == (last_grant + 1) % N, "R3 rotation", W'(p), W'((last_grant + 1) % N));
          last_grant = p;
        end
      end
      if (out_valid[p] && out_ready[p]) begin
        chk(out_id == 2'(p), "R5 tag", W'(out_id), W'(p));
        if (expq[p].size() == 0) chk(0, "R6 unexpected result", out_z, 0);
        else begin
          logic [W-1:0] e;
          e = expq[p].pop_front();
          chk(out_z == e, "R4/R6 value and order", out_z, e);
          got[p]++;
        end
      end
      if (!pend[p] && left[p] > 0) begin
        if (gap[p] == 0) new_item(p);
        else gap[p]--;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int p = 0; p < N; p++) begin
      pend[p] = 0; gap[p] = 0; left[p] = 0; got[p] = 0; pa[p] = '0; pb[p] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 0 && in_ready == 0, "R1 in reset", W'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) step();
    chk(out_valid == 0, "R1 after reset", W'(out_valid), 0);

    // R7: single item on port 2 into an empty pipeline
    pa[2] = 32'd5; pb[2] = 32'd7; pend[2] = 1; left[2] = 1;
    step();
    chk(expq[2].size() == 1, "R7 accepted", W'(expq[2].size()), 1);
    step();
    chk(out_valid == 0, "R7 not early c+1", W'(out_valid), 0);
    step();
    chk(out_valid == 0, "R7 not early c+2", W'(out_valid), 0);
    step();
    chk(out_valid == 4'b0100 && out_z == 32'd12, "R7 latency c+3", out_z, 32'd12);
    chk(got[2] == 1, "R7 delivered", W'(got[2]), 1);

    // R3: all ports valid continuously
    rr_on = 1; gap_max = 0;
    for (int p = 0; p < N; p++) begin left[p] = 4; new_item(p); end
    repeat (30) step();
    rr_on = 0;
    for (int p = 0; p < N; p++) chk(expq[p].size() == 0, "R3 drained", W'(expq[p].size()), 0);

    // R4 R6 R8 R9: random gaps and random stalls
    gap_max = 3; rand_rdy = 1;
    for (int p = 0; p < N; p++) begin left[p] = NITEM; got[p] = 0; gap[p] = $urandom_range(0, 3); end
    repeat (600) step();
    rand_rdy = 0;
    repeat (40) step();
    for (int p = 0; p < N; p++) begin
      chk(expq[p].size() == 0 && left[p] == 0, "R9 all sent and received", W'(expq[p].size()), 0);
      chk(got[p] == NITEM, "R9 result count", W'(got[p]), W'(NITEM));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule